// File: doc/BRIEF.md
# Parallel Poll Response Unit

This unit forms an instrument's answer to a parallel poll. A host keeps an 8-bit enable mask in the unit and can read it back at any time. The unit ANDs the mask with the live status byte. A nonzero result sets the local individual status flag, and a zero result clears it.

The controller first issues a configure step and then sends an enable byte. The unit takes two things from that byte: a sense bit and a 3-bit line number. During a poll, the selected data line is asserted when the status flag equals the sense. Every other line is released, so several instruments can share a line in a wired-AND or wired-OR arrangement.

The unit has two outputs toward the bus: a response byte and a per-bit drive enable. The physical drivers, the bus handshake and command parsing are handled around it.

Top module: `ppoll_resp_unit`

## Requirements
- R1: After synchronous reset the mask reads 0, the unit is unconfigured, and no line is driven during a poll.
- R2: A host write loads the mask on the next rising clock edge, and `pp_mask_q` then shows the written value.
- R3: `ist` is 1 exactly when the AND of the mask and `status_byte` is nonzero, and it follows both without a clock.
- R4: An enable byte is accepted only if a configure pulse came in an earlier cycle with no other enable byte in between. An enable byte without one is ignored, and every enable byte consumes the pending configure.
- R5: An enable byte is valid only if bits 6:4 are 110, and bit 7 has no effect. A byte with any other bits 6:4 pattern leaves the previous configuration unchanged.
- R6: Bit 3 of the accepted byte is the sense. The selected line is asserted only while `ist` equals the sense.
- R7: Bits 2:0 of the accepted byte give line number P, which maps to bit P of `resp_data` and `resp_drive`, with bit 0 as the least significant bit.
- R8: `resp_drive` has at most one bit set. `resp_data` is 1 only where it is driven, so unselected lines, and the selected line while not asserted, are released (data 0, drive 0).
- R9: A disable pulse clears the configuration and any pending configure. Disable takes priority over a configure or enable byte in the same cycle. While unconfigured, nothing is driven.
- R10: The response depends combinationally on `poll_req` and the current `ist`. No line is driven while `poll_req` is low, and a status change during a poll shows up without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr | input | 1 | Host write strobe for the enable mask |
| mask_wdata | input | 8 | Mask value to write |
| pp_mask_q | output | 8 | Current enable mask (host readback) |
| status_byte | input | 8 | Live instrument status byte |
| cmd_cfg | input | 1 | Configure pulse; arms acceptance of one enable byte |
| cmd_dis | input | 1 | Disable pulse; clears the configuration |
| en_valid | input | 1 | Enable byte strobe |
| en_byte | input | 8 | Enable byte: bits 6:4 pattern, bit 3 sense, bits 2:0 line |
| poll_req | input | 1 | Parallel poll in progress |
| ist | output | 1 | Local individual status flag |
| resp_data | output | 8 | Response byte (1 = line asserted) |
| resp_drive | output | 8 | Per-line drive enable (0 = released) |

## Verification
The bench builds the unit with its default 8-line width. At that width the 3-bit line field of the enable byte covers every data line, so the vectors can place the response on the lowest line, the highest line and several lines in between, with both sense values. The mask and status patterns in the vectors make the flag true through a single shared bit, and false through disjoint bits and through an empty mask. Directed cases at this width cover:
- an enable byte sent without a configure step;
- a malformed enable byte;
- a second enable byte after one has been accepted;
- disable;
- a status change in the middle of a poll.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int PPR_SEL_W = 3;
    localparam int PPR_LINES = 1 << PPR_SEL_W;
    localparam int PPR_BYTE_W = 8;

    // Fixed pattern carried in bits 6:4 of a valid enable byte
    localparam logic [2:0] PPR_EN_TAG = 3'b110;

    typedef struct packed {
        logic                 valid;
        logic                 sense;
        logic [PPR_SEL_W-1:0] line;
    } ppr_cfg_t;

    typedef enum logic [1:0] {
        ARM_IDLE  = 2'b00,
        ARM_ARMED = 2'b01
    } ppr_arm_e;

    function automatic logic ppr_is_enable(input logic [PPR_BYTE_W-1:0] b);
        return b[6:4] == PPR_EN_TAG;
    endfunction

    function automatic ppr_cfg_t ppr_decode(input logic [PPR_BYTE_W-1:0] b);
        ppr_cfg_t c;
        c.valid = 1'b1;
        c.sense = b[3];
        c.line  = b[PPR_SEL_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/ppr_mask_reg.sv
module ppr_mask_reg
    import ppr_pkg::*;
#(
    parameter int DATA_W = PPR_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_byte,
    output logic [DATA_W-1:0] mask_q,
    output logic              ist
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr) begin
            mask_q <= wdata;
        end
    end

    assign ist = |(mask_q & status_byte);

endmodule

// File: rtl/ppr_cfg_decoder.sv
module ppr_cfg_decoder
    import ppr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_cfg,
    input  logic                  cmd_dis,
    input  logic                  en_valid,
    input  logic [PPR_BYTE_W-1:0] en_byte,
    output ppr_cfg_t              cfg_q
);

    ppr_arm_e arm_q;
    logic     accept;
    logic     unused_top_bit;

    assign unused_top_bit = en_byte[7];
    assign accept = en_valid && (arm_q == ARM_ARMED) && ppr_is_enable(en_byte);

    always_ff @(posedge clk) begin
        if (rst || cmd_dis) begin
            arm_q <= ARM_IDLE;
            cfg_q <= '0;
        end else begin
            if (accept) begin
                cfg_q <= ppr_decode(en_byte);
            end
            if (cmd_cfg) begin
                arm_q <= ARM_ARMED;
            end else if (en_valid) begin
                arm_q <= ARM_IDLE;
            end
        end
    end

endmodule

// File: rtl/ppr_line_driver.sv
module ppr_line_driver
    import ppr_pkg::*;
#(
    parameter int DATA_W = PPR_LINES,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              poll_req,
    input  logic              ist,
    input  ppr_cfg_t          cfg,
    output logic [DATA_W-1:0] resp_data,
    output logic [DATA_W-1:0] resp_drive
);

    logic asserted;

    assign asserted = poll_req && cfg.valid && (ist == cfg.sense);

    for (genvar i = 0; i < DATA_W; i++) begin : g_line
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        logic hit;
        assign hit           = asserted && (cfg.line[SEL_W-1:0] == IDX);
        assign resp_drive[i] = hit;
        assign resp_data[i]  = hit;
    end

endmodule

// File: rtl/ppoll_resp_unit.sv
module ppoll_resp_unit
    import ppr_pkg::*;
#(
    parameter int DATA_W = PPR_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    output logic [DATA_W-1:0] pp_mask_q,
    input  logic [DATA_W-1:0] status_byte,
    input  logic              cmd_cfg,
    input  logic              cmd_dis,
    input  logic              en_valid,
    input  logic [PPR_BYTE_W-1:0] en_byte,
    input  logic              poll_req,
    output logic              ist,
    output logic [DATA_W-1:0] resp_data,
    output logic [DATA_W-1:0] resp_drive
);

    ppr_cfg_t cfg_q;

    ppr_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk         (clk),
        .rst         (rst),
        .wr          (mask_wr),
        .wdata       (mask_wdata),
        .status_byte (status_byte),
        .mask_q      (pp_mask_q),
        .ist         (ist)
    );

    ppr_cfg_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_cfg  (cmd_cfg),
        .cmd_dis  (cmd_dis),
        .en_valid (en_valid),
        .en_byte  (en_byte),
        .cfg_q    (cfg_q)
    );

    ppr_line_driver #(.DATA_W(DATA_W)) u_drv (
        .poll_req   (poll_req),
        .ist        (ist),
        .cfg        (cfg_q),
        .resp_data  (resp_data),
        .resp_drive (resp_drive)
    );

endmodule

// File: rtl/ppr_checker.sv
module ppr_checker
    import ppr_pkg::*;
#(
    parameter int DATA_W = PPR_LINES
) (
    input logic              clk,
    input logic              rst,
    input logic              mask_wr,
    input logic [DATA_W-1:0] mask_wdata,
    input logic [DATA_W-1:0] pp_mask_q,
    input logic [DATA_W-1:0] status_byte,
    input logic              cmd_dis,
    input logic              poll_req,
    input logic              ist,
    input logic [DATA_W-1:0] resp_data,
    input logic [DATA_W-1:0] resp_drive
);

    assert_single_line_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resp_drive));

    assert_released_low_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_data & ~resp_drive) == '0);

    assert_idle_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        !poll_req |-> resp_drive == '0);

    assert_ist_from_mask_R3: assert property (@(posedge clk) disable iff (rst)
        ist == |(pp_mask_q & status_byte));

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> pp_mask_q == $past(mask_wdata));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_dis |=> resp_drive == '0);

endmodule

bind ppoll_resp_unit ppr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mask_wr     (mask_wr),
    .mask_wdata  (mask_wdata),
    .pp_mask_q   (pp_mask_q),
    .status_byte (status_byte),
    .cmd_dis     (cmd_dis),
    .poll_req    (poll_req),
    .ist         (ist),
    .resp_data   (resp_data),
    .resp_drive  (resp_drive)
);

// File: tb/sim_ppoll_resp_unit.sv
module sim_ppoll_resp_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] pp_mask_q;
    logic [7:0] status_byte = '0;
    logic       cmd_cfg = 1'b0;
    logic       cmd_dis = 1'b0;
    logic       en_valid = 1'b0;
    logic [7:0] en_byte = '0;
    logic       poll_req = 1'b0;
    logic       ist;
    logic [7:0] resp_data;
    logic [7:0] resp_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ppoll_resp_unit u0 (.*);

    // {mask, status, enable byte, expected ist, expected response}
    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] stat;
        logic [7:0] enb;
        logic       eist;
        logic [7:0] eresp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h40, 8'h40, 8'h69, 1'b1, 8'h02},
        '{8'h40, 8'h00, 8'h69, 1'b0, 8'h00},
        '{8'h0F, 8'h30, 8'h65, 1'b0, 8'h20},
        '{8'h0F, 8'h01, 8'h65, 1'b1, 8'h00},
        '{8'hFF, 8'h80, 8'hE8, 1'b1, 8'h01},
        '{8'h81, 8'h7E, 8'h67, 1'b0, 8'h80},
        '{8'h00, 8'hFF, 8'h6C, 1'b0, 8'h00},
        '{8'h10, 8'h10, 8'h6E, 1'b1, 8'h40}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [7:0] v);
        @(negedge clk); mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic pulse_cfg();
        @(negedge clk); cmd_cfg = 1'b1;
        @(negedge clk); cmd_cfg = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); cmd_dis = 1'b1;
        @(negedge clk); cmd_dis = 1'b0;
    endtask

    task automatic send_en(input logic [7:0] b);
        @(negedge clk); en_valid = 1'b1; en_byte = b;
        @(negedge clk); en_valid = 1'b0;
    endtask

    task automatic poll_check(input string req, input logic [7:0] stat, input logic [7:0] exp);
        @(negedge clk); status_byte = stat; poll_req = 1'b1;
        #1;
        check8(req, resp_drive, exp);
        check8(req, resp_data, exp);
        poll_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check8("R1 mask after reset", pp_mask_q, 8'h00);
        check8("R1 ist after reset", {7'd0, ist}, 8'h00);
        poll_check("R1 no drive when unconfigured", 8'hFF, 8'h00);

        // Table walk: R2 R3 R5 R6 R7
        foreach (VECS[k]) begin
            wr_mask(VECS[k].mask);
            check8("R2 mask readback", pp_mask_q, VECS[k].mask);
            pulse_cfg();
            send_en(VECS[k].enb);
            @(negedge clk); status_byte = VECS[k].stat; #1;
            check8("R3 ist", {7'd0, ist}, {7'd0, VECS[k].eist});
            poll_check("R6 R7 vector response", VECS[k].stat, VECS[k].eresp);
        end

        // R10: not polling means no drive
        @(negedge clk); poll_req = 1'b0; status_byte = 8'h10; #1;
        check8("R10 idle no drive", resp_drive, 8'h00);

        // R10: live status change during poll (mask 10, line 6, sense 1)
        @(negedge clk); poll_req = 1'b1; status_byte = 8'h10; #1;
        check8("R10 poll asserted", resp_drive, 8'h40);
        #3 status_byte = 8'h00; #1;
        check8("R10 live drop", resp_drive, 8'h00);
        check8("R8 released data", resp_data, 8'h00);
        poll_req = 1'b0;

        // R4: second byte without a new configure is ignored
        send_en(8'h6A);
        poll_check("R4 stale byte ignored", 8'h10, 8'h40);

        // R5: malformed byte after configure leaves config unchanged
        pulse_cfg();
        send_en(8'h49);
        poll_check("R5 malformed ignored", 8'h10, 8'h40);

        // R4: malformed byte consumed the arm; a valid byte now is ignored
        send_en(8'h69);
        poll_check("R4 arm consumed", 8'h10, 8'h40);

        // R9: disable clears configuration
        pulse_dis();
        poll_check("R9 disabled", 8'h10, 8'h00);
        poll_check("R9 disabled other sense", 8'h00, 8'h00);

        // R4: enable byte with no configure after disable is ignored
        send_en(8'h69);
        wr_mask(8'h40);
        poll_check("R4 no configure", 8'h40, 8'h00);

        // R5: malformed pattern from unconfigured stays unconfigured
        pulse_cfg();
        send_en(8'h79);
        poll_check("R5 bad tag", 8'h40, 8'h00);

        // R9: disable wins over a same-cycle enable byte
        pulse_cfg();
        @(negedge clk); cmd_dis = 1'b1; en_valid = 1'b1; en_byte = 8'h69;
        @(negedge clk); cmd_dis = 1'b0; en_valid = 1'b0;
        poll_check("R9 disable priority", 8'h40, 8'h00);

        // R1: reset clears mask and configuration
        pulse_cfg();
        send_en(8'h69);
        poll_check("R6 before reset", 8'h40, 8'h02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check8("R1 mask cleared", pp_mask_q, 8'h00);
        wr_mask(8'h40);
        poll_check("R1 config cleared", 8'h40, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule